// File: doc/BRIEF.md
# SD Card Command Launch Controller

This block sits between a software-visible register pair and the engine that serializes commands onto an SD/MMC card bus. Software first writes a 32-bit argument, then a packed command word whose top bit asks the block to load it. The block keeps that request pending and shows the load flag as set on read-back. Once the card is no longer busy, the previous command has finished, and any requested wait for the data path is over, the block fires a one-cycle launch toward the card-side engine. The launch carries the latched index, flags and argument. Hardware then clears the load flag.

A command word that carries the clock-update marker is a special case. It is accepted at once and produces a one-cycle clock-update strobe. Nothing is launched on the card bus. The card-side engine reports the end of each command with a done pulse and an error code. The block turns these into a completion pulse and a held error code. A response-CRC error code is dropped when the command did not ask for CRC checking, as for response types that carry no valid CRC.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, the load flag, launch, clock-update strobe, completion pulse, error code and all status bits are 0.
- R2: A write to the command register (wr_sel=0) with bit 31 set makes read-back bit 31 equal 1. When the command is launched, `launch` is high for exactly one cycle, `launch_cmd` equals bits 15:0 of the written word, `launch_arg` equals the last argument written (wr_sel=1), and read-back bit 31 returns to 0.
- R3: A loaded command word with bit 21 set produces a one-cycle `clk_upd` pulse and clears the load flag in the cycle after the load, even while the card is busy. No launch is issued.
- R4: No launch is issued while `card_busy` is high. A pending load launches in the cycle after `card_busy` falls.
- R5: When bit 13 of the command is set, the launch waits until `dat_busy` is low. When bit 13 is clear, `dat_busy` has no effect.
- R6: While the load flag is set, writes to the command register and to the argument register are ignored.
- R7: When `eng_done` is high while a command is active, `cmd_done` pulses for one cycle on the next cycle. `cmd_err` takes the engine's error code and holds it until the next completion.
- R8: When bit 8 (check response CRC) of the launched command is clear, a response-CRC error code (value 2) from the engine is reported as 0. Other codes pass through. When bit 8 is set, code 2 is reported unchanged.
- R9: A new command is not launched while the previous one is active. It launches in the cycle after the completion pulse.
- R10: `status` bit 0 is the load flag, bit 1 shows that a launched command is awaiting completion, and bit 2 mirrors `card_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command word, 1 selects the argument |
| wr_data | input | 32 | Write data |
| rd_cmd | output | 32 | Command word read-back, with the load flag in bit 31 |
| rd_arg | output | ARG_W | Argument read-back |
| card_busy | input | 1 | Card signals busy |
| dat_busy | input | 1 | Previous data phase still running |
| status | output | 3 | {card busy, command active, load pending} |
| launch | output | 1 | One-cycle command start toward the engine |
| launch_cmd | output | 16 | Latched index and flags of the launched command |
| launch_arg | output | ARG_W | Latched argument of the launched command |
| clk_upd | output | 1 | One-cycle clock-update strobe |
| eng_done | input | 1 | Engine finished the command |
| eng_err | input | ERR_W | Engine error code, 0 meaning none |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | ERR_W | Error code of the last completed command |

## Verification
The bench builds the block with its default values: a 32-bit argument and a 2-bit error code with code 2 as the response-CRC error. With these values the CRC masking rule can be tested against both a masked code and one that passes through. Directed scenarios hold `card_busy`, `dat_busy` and an active command high across several cycles. This shows that each gate delays the launch by exactly one cycle after it is released. Writes are issued while a load is pending to show that the command and argument registers stay unchanged.

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue #(
  parameter int ARG_W = 32,
  parameter int ERR_W = 2,
  parameter logic [ERR_W-1:0] CRC_ERR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_cmd,
  output logic [ARG_W-1:0] rd_arg,
  input  logic             card_busy,
  input  logic             dat_busy,
  output logic [2:0]       status,
  output logic             launch,
  output logic [15:0]      launch_cmd,
  output logic [ARG_W-1:0] launch_arg,
  output logic             clk_upd,
  input  logic             eng_done,
  input  logic [ERR_W-1:0] eng_err,
  output logic             cmd_done,
  output logic [ERR_W-1:0] cmd_err
);
  localparam int B_CRC  = 8;
  localparam int B_WAIT = 13;
  localparam int B_CLK  = 21;

  logic [30:0]      cmd_q;
  logic             load_q;
  logic [ARG_W-1:0] arg_q;
  logic             active_q;
  logic             launch_q;
  logic             upd_q;
  logic             done_q;
  logic [ERR_W-1:0] err_q;
  logic [15:0]      lcmd_q;
  logic [ARG_W-1:0] larg_q;

  wire upd_ok = load_q & cmd_q[B_CLK];
  wire go_ok  = load_q & ~cmd_q[B_CLK] & ~active_q & ~card_busy
              & ~(cmd_q[B_WAIT] & dat_busy);
  wire crc_masked = (eng_err == CRC_ERR) & ~lcmd_q[B_CRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      load_q   <= 1'b0;
      arg_q    <= '0;
      active_q <= 1'b0;
      launch_q <= 1'b0;
      upd_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= '0;
      lcmd_q   <= '0;
      larg_q   <= '0;
    end else begin
      launch_q <= go_ok;
      upd_q    <= upd_ok;
      done_q   <= 1'b0;
      if (wr_en && !load_q) begin
        if (!wr_sel) {load_q, cmd_q} <= wr_data;
        else         arg_q <= wr_data[ARG_W-1:0];
      end else if (go_ok || upd_ok) begin
        load_q <= 1'b0;
      end
      if (go_ok) begin
        active_q <= 1'b1;
        lcmd_q   <= cmd_q[15:0];
        larg_q   <= arg_q;
      end
      if (active_q && eng_done) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        err_q    <= crc_masked ? '0 : eng_err;
      end
    end
  end

  assign rd_cmd     = {load_q, cmd_q};
  assign rd_arg     = arg_q;
  assign status     = {card_busy, active_q, load_q};
  assign launch     = launch_q;
  assign launch_cmd = lcmd_q;
  assign launch_arg = larg_q;
  assign clk_upd    = upd_q;
  assign cmd_done   = done_q;
  assign cmd_err    = err_q;
endmodule

module sd_cmd_issue_chk #(
  parameter int ARG_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_cmd,
  input logic        card_busy,
  input logic        dat_busy,
  input logic [2:0]  status,
  input logic        launch,
  input logic [15:0] launch_cmd,
  input logic        clk_upd,
  input logic        eng_done,
  input logic        cmd_done
);
  assert_launch_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  assert_launch_clears_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !rd_cmd[31]);
  assert_clkupd_no_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_upd |-> !launch);
  assert_no_launch_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(launch) |-> $past(!card_busy));
  assert_wait_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(launch) && launch_cmd[13]) |-> $past(!dat_busy));
  assert_hold_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd[31] && $past(rd_cmd[31])) |-> $stable(rd_cmd));
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(eng_done));
  assert_no_launch_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(launch) |-> !$past(status[1]));
endmodule

bind sd_cmd_issue sd_cmd_issue_chk #(.ARG_W(ARG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .card_busy(card_busy),
  .dat_busy(dat_busy), .status(status), .launch(launch),
  .launch_cmd(launch_cmd), .clk_upd(clk_upd), .eng_done(eng_done),
  .cmd_done(cmd_done)
);

// File: tb/test_sd_cmd_issue.sv
module test_sd_cmd_issue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_cmd, rd_arg, launch_arg;
  logic        card_busy = 1'b0, dat_busy = 1'b0;
  logic [2:0]  status;
  logic        launch, clk_upd, cmd_done;
  logic [15:0] launch_cmd;
  logic        eng_done = 1'b0;
  logic [1:0]  eng_err = '0, cmd_err;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sd_cmd_issue i_sd_cmd_issue (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_cmd(rd_cmd), .rd_arg(rd_arg), .card_busy(card_busy), .dat_busy(dat_busy),
    .status(status), .launch(launch), .launch_cmd(launch_cmd),
    .launch_arg(launch_arg), .clk_upd(clk_upd), .eng_done(eng_done),
    .eng_err(eng_err), .cmd_done(cmd_done), .cmd_err(cmd_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic finish_cmd(logic [1:0] code, logic [1:0] exp_err, string req);
    eng_done = 1'b1; eng_err = code;
    step();
    eng_done = 1'b0; eng_err = '0;
    chk({req, " done pulse"}, cmd_done, 1);
    chk({req, " error code"}, cmd_err, exp_err);
    chk({req, " active cleared"}, status[1], 0);
    step();
    chk({req, " done one cycle"}, cmd_done, 0);
    chk({req, " error held"}, cmd_err, exp_err);
  endtask

  task automatic t_reset;
    chk("R1 load", rd_cmd[31], 0);
    chk("R1 launch", launch, 0);
    chk("R1 clk_upd", clk_upd, 0);
    chk("R1 done", cmd_done, 0);
    chk("R1 err", cmd_err, 0);
    chk("R1 status", status, 0);
  endtask

  task automatic t_basic;
    wr(1'b1, 32'hCAFE_0001);
    wr(1'b0, 32'h8000_0151);
    chk("R2 load set", rd_cmd[31], 1);
    chk("R10 status load", status, 3'b001);
    step();
    chk("R2 launch", launch, 1);
    chk("R2 launch_cmd", launch_cmd, 16'h0151);
    chk("R2 launch_arg", launch_arg, 32'hCAFE_0001);
    chk("R2 load cleared", rd_cmd[31], 0);
    chk("R10 status active", status, 3'b010);
    step();
    chk("R2 single pulse", launch, 0);
    finish_cmd(2'd0, 2'd0, "R7");
  endtask

  task automatic t_card_busy;
    card_busy = 1'b1;
    wr(1'b0, 32'h8000_0152);
    step(3);
    chk("R4 held", launch, 0);
    chk("R4 pending", rd_cmd[31], 1);
    chk("R10 busy bit", status, 3'b101);
    card_busy = 1'b0;
    step();
    chk("R4 launch after release", launch, 1);
    finish_cmd(2'd1, 2'd1, "R7 timeout");
  endtask

  task automatic t_wait_prev;
    dat_busy = 1'b1;
    wr(1'b0, 32'h8000_2352);
    step(3);
    chk("R5 held by dat_busy", launch, 0);
    dat_busy = 1'b0;
    step();
    chk("R5 launch after data idle", launch, 1);
    finish_cmd(2'd0, 2'd0, "R5");
    dat_busy = 1'b1;
    wr(1'b0, 32'h8000_0153);
    step();
    chk("R5 no wait bit ignores dat_busy", launch, 1);
    dat_busy = 1'b0;
    finish_cmd(2'd0, 2'd0, "R5b");
  endtask

  task automatic t_ignore;
    card_busy = 1'b1;
    wr(1'b1, 32'h1111_2222);
    wr(1'b0, 32'h8000_0144);
    wr(1'b0, 32'h8000_0155);
    wr(1'b1, 32'h3333_4444);
    chk("R6 cmd unchanged", rd_cmd, 32'h8000_0144);
    chk("R6 arg unchanged", rd_arg, 32'h1111_2222);
    card_busy = 1'b0;
    step();
    chk("R6 launched first cmd", launch_cmd, 16'h0144);
    chk("R6 launched first arg", launch_arg, 32'h1111_2222);
    finish_cmd(2'd0, 2'd0, "R6");
  endtask

  task automatic t_clk_update;
    card_busy = 1'b1;
    wr(1'b0, 32'h8020_0000);
    chk("R3 load set", rd_cmd[31], 1);
    step();
    chk("R3 strobe", clk_upd, 1);
    chk("R3 no launch", launch, 0);
    chk("R3 load cleared", rd_cmd[31], 0);
    step();
    chk("R3 strobe one cycle", clk_upd, 0);
    chk("R3 still no launch", launch, 0);
    card_busy = 1'b0;
  endtask

  task automatic t_crc_mask;
    wr(1'b0, 32'h8000_0045);
    step();
    chk("R8 launch no-crc", launch, 1);
    finish_cmd(2'd2, 2'd0, "R8 masked");
    wr(1'b0, 32'h8000_0046);
    step();
    finish_cmd(2'd3, 2'd3, "R8 pass other");
    wr(1'b0, 32'h8000_0147);
    step();
    finish_cmd(2'd2, 2'd2, "R8 crc checked");
  endtask

  task automatic t_active_block;
    wr(1'b0, 32'h8000_0148);
    step();
    chk("R9 first launch", launch, 1);
    wr(1'b0, 32'h8000_0149);
    step(2);
    chk("R9 held while active", launch, 0);
    chk("R9 pending", rd_cmd[31], 1);
    eng_done = 1'b1;
    step();
    eng_done = 1'b0;
    chk("R9 done pulse", cmd_done, 1);
    chk("R9 not yet launched", launch, 0);
    step();
    chk("R9 launch after done", launch, 1);
    chk("R9 second cmd", launch_cmd, 16'h0149);
    finish_cmd(2'd0, 2'd0, "R9");
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step();
    t_basic();
    t_card_busy();
    t_wait_prev();
    t_ignore();
    t_clk_update();
    t_crc_mask();
    t_active_block();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule